// File: doc/BRIEF.md
# Tiered Shared-Bus Arbiter

This block decides which requester owns a single wide shared memory bus. Three classes of requester compete for it. The host link port outranks everything. The inter-node serial link port comes next. Below those sit a parameterised number of local function ports, which have equal standing and take turns in rotating order. The transfer engine that moves the data asserts a completion pulse when the current owner's transfer is finished. The arbiter keeps the grant steady until that pulse arrives.

Grants are registered. A request seen while the bus is free produces a grant on the next clock edge. The grant then stays fixed, whatever the request lines do, until the completion pulse. The cycle after the pulse is a free cycle with no owner, and the arbiter decides again in that cycle. The grant comes out twice: as a one-hot vector and as a binary slot number. In both, slot 0 is the host link, slot 1 is the serial link and slot 2+k is function k.

Top module: `bus_tier_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low), grant is all zeros and grant_idx is 0.
- R2: At most one bit of grant is set. When a bit is set, grant_idx holds its position (bit 0 host link, bit 1 serial link, bit 2+k function k). When grant is all zeros, grant_idx is 0.
- R3: If the bus is free and host_req is high at a clock edge, grant becomes 6'b000001 (host slot 0) after that edge, whatever the other requests are.
- R4: If the bus is free, host_req is low and link_req is high at an edge, grant selects slot 1 after that edge, whatever fn_req is.
- R5: If only function requests are present on a free bus, the grant goes to the first requesting function at or after the rotation pointer, wrapping from NUM_FN-1 to 0. The pointer is 0 after reset. After function k is granted, the pointer becomes k+1 (modulo NUM_FN).
- R6: While a grant is held and xfer_done is low, grant and grant_idx do not change, even if request lines rise or fall.
- R7: An edge with a grant held and xfer_done high clears grant to all zeros. The next arbitration decision uses the requests present in the following cycle.
- R8: xfer_done has no effect while no grant is held: grant stays zero and the rotation pointer does not move.
- R9: With no request at all on a free bus, grant stays all zeros.
- R10: Host-link and serial-link grants leave the rotation pointer unchanged.
- R11: With every function requesting continuously and host grants interleaved, over 2*NUM_FN function grants each function is granted exactly twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host link port requests the bus |
| link_req | input | 1 | Serial inter-node link port requests the bus |
| fn_req | input | NUM_FN | One request line per local function |
| xfer_done | input | 1 | Transfer engine reports the owner's transfer complete |
| grant | output | NUM_FN+2 | One-hot bus grant: bit 0 host, bit 1 link, bit 2+k function k |
| grant_idx | output | $clog2(NUM_FN+2) | Binary slot number of the current owner, 0 when idle |

## Verification
The assertions check on every cycle the properties that depend only on one or two neighbouring cycles: grant exclusivity and agreement with grant_idx, the two fixed tiers winning on a free bus, the hold while xfer_done is low, the release on xfer_done, and the idle result. Rotation order needs the pointer's history across many grants, so only the bench's scenarios show it. The same applies to the pointer staying put across host grants, link grants and stray completion pulses, and to the equal share each function gets under saturated requests with host traffic between them. The bench checks these against a model of the pointer it keeps itself.

// File: rtl/arb_tier_pkg.sv
package arb_tier_pkg;

    localparam int unsigned HOST_SLOT = 0;
    localparam int unsigned LINK_SLOT = 1;
    localparam int unsigned FN_BASE   = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOST = 2'd1,
        SRC_LINK = 2'd2,
        SRC_FN   = 2'd3
    } src_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int unsigned NUM_FN = 4,
    parameter int unsigned PW     = 2
) (
    input  logic [NUM_FN-1:0] fn_req,
    input  logic [PW-1:0]     ptr,
    output logic              hit,
    output logic [PW-1:0]     pick
);

    // Scan from the farthest offset down to zero so that the nearest
    // requester at or after the pointer is the last one assigned.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int off = int'(NUM_FN) - 1; off >= 0; off--) begin
            int unsigned pos;
            pos = (int'(ptr) + off) % NUM_FN;
            if (fn_req[pos]) begin
                hit  = 1'b1;
                pick = PW'(pos);
            end
        end
    end

endmodule

// File: rtl/arb_tier_sel.sv
module arb_tier_sel
    import arb_tier_pkg::*;
#(
    parameter int unsigned NUM_FN = 4,
    parameter int unsigned PW     = 2,
    parameter int unsigned NREQ   = NUM_FN + 2,
    parameter int unsigned IW     = 3
) (
    input  logic            host_req,
    input  logic            link_req,
    input  logic            fn_hit,
    input  logic [PW-1:0]   fn_pick,
    output logic [NREQ-1:0] win_vec,
    output logic [IW-1:0]   win_idx,
    output src_e            win_src
);

    always_comb begin
        win_vec = '0;
        win_idx = '0;
        win_src = SRC_NONE;
        if (host_req) begin
            win_vec[HOST_SLOT] = 1'b1;
            win_idx            = IW'(HOST_SLOT);
            win_src            = SRC_HOST;
        end else if (link_req) begin
            win_vec[LINK_SLOT] = 1'b1;
            win_idx            = IW'(LINK_SLOT);
            win_src            = SRC_LINK;
        end else if (fn_hit) begin
            win_idx          = IW'(FN_BASE) + IW'(fn_pick);
            win_vec[win_idx] = 1'b1;
            win_src          = SRC_FN;
        end
    end

endmodule

// File: rtl/bus_tier_arbiter.sv
module bus_tier_arbiter
    import arb_tier_pkg::*;
#(
    parameter int unsigned NUM_FN = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_req,
    input  logic                            link_req,
    input  logic [NUM_FN-1:0]               fn_req,
    input  logic                            xfer_done,
    output logic [NUM_FN+1:0]               grant,
    output logic [$clog2(NUM_FN+2)-1:0]     grant_idx
);

    localparam int unsigned NREQ = NUM_FN + 2;
    localparam int unsigned IW   = $clog2(NREQ);
    localparam int unsigned PW   = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;
    localparam logic [PW-1:0] LAST_FN = PW'(NUM_FN - 1);

    typedef struct packed {
        logic            busy;
        logic [NREQ-1:0] gnt;
        logic [IW-1:0]   idx;
        logic [PW-1:0]   ptr;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic            fn_hit;
    logic [PW-1:0]   fn_pick;
    logic [NREQ-1:0] win_vec;
    logic [IW-1:0]   win_idx;
    src_e            win_src;

    arb_rr_pick #(
        .NUM_FN (NUM_FN),
        .PW     (PW)
    ) u_rr (
        .fn_req (fn_req),
        .ptr    (st_q.ptr),
        .hit    (fn_hit),
        .pick   (fn_pick)
    );

    arb_tier_sel #(
        .NUM_FN (NUM_FN),
        .PW     (PW),
        .NREQ   (NREQ),
        .IW     (IW)
    ) u_sel (
        .host_req (host_req),
        .link_req (link_req),
        .fn_hit   (fn_hit),
        .fn_pick  (fn_pick),
        .win_vec  (win_vec),
        .win_idx  (win_idx),
        .win_src  (win_src)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (xfer_done) begin
                st_d.busy = 1'b0;
                st_d.gnt  = '0;
                st_d.idx  = '0;
            end
        end else begin
            st_d.busy = (win_src != SRC_NONE);
            st_d.gnt  = win_vec;
            st_d.idx  = win_idx;
            if (win_src == SRC_FN) begin
                st_d.ptr = (fn_pick == LAST_FN) ? '0 : fn_pick + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = st_q.gnt;
    assign grant_idx = st_q.idx;

endmodule

// File: rtl/arb_tier_chk.sv
module arb_tier_chk #(
    parameter int unsigned NUM_FN = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        host_req,
    input logic                        link_req,
    input logic [NUM_FN-1:0]           fn_req,
    input logic                        xfer_done,
    input logic [NUM_FN+1:0]           grant,
    input logic [$clog2(NUM_FN+2)-1:0] grant_idx
);

    localparam int unsigned NREQ = NUM_FN + 2;

    logic bus_free;
    logic no_req;
    assign bus_free = (grant == '0);
    assign no_req   = !host_req && !link_req && (fn_req == '0);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (grant == '0 && grant_idx == '0));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_idx_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_free |-> grant[grant_idx]);

    assert_idx_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> (grant_idx == '0));

    assert_host_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && host_req) |=> (grant[0] && grant_idx == '0));

    assert_link_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && !host_req && link_req) |=> grant[1]);

    assert_fn_tier_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && !host_req && !link_req && fn_req != '0)
            |=> (grant[NREQ-1:2] != '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_free && !xfer_done) |=> ($stable(grant) && $stable(grant_idx)));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_free && xfer_done) |=> (grant == '0));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && no_req) |=> (grant == '0));

endmodule

bind bus_tier_arbiter arb_tier_chk #(
    .NUM_FN (NUM_FN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .link_req  (link_req),
    .fn_req    (fn_req),
    .xfer_done (xfer_done),
    .grant     (grant),
    .grant_idx (grant_idx)
);

// File: tb/bus_tier_arbiter_tb.sv
module bus_tier_arbiter_tb;

    localparam int N       = 4;
    localparam int NREQ    = N + 2;
    localparam int IW      = $clog2(NREQ);
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            host_req;
    logic            link_req;
    logic [N-1:0]    fn_req;
    logic            xfer_done;
    logic [NREQ-1:0] grant;
    logic [IW-1:0]   grant_idx;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_q[$];
    int mptr   = 0;
    int fn_cnt[N];
    logic [NREQ-1:0] prev_gnt = '0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_tier_arbiter #(.NUM_FN(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .link_req  (link_req),
        .fn_req    (fn_req),
        .xfer_done (xfer_done),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(int slot);
        if (slot == 0) return "R3 host first";
        if (slot == 1) return "R4 link second";
        return "R5 round robin";
    endfunction

    // Model of the requirements: push the slot that must win next.
    task automatic predict(bit h, bit l, logic [N-1:0] f);
        if (h) exp_q.push_back(0);
        else if (l) exp_q.push_back(1);
        else begin
            for (int off = 0; off < N; off++) begin
                int pos;
                pos = (mptr + off) % N;
                if (f[pos]) begin
                    exp_q.push_back(2 + pos);
                    mptr = (pos + 1) % N;
                    break;
                end
            end
        end
    endtask

    task automatic round(bit h, bit l, logic [N-1:0] f, int hold, bit disturb);
        logic [NREQ-1:0] held;
        @(negedge clk);
        host_req = h; link_req = l; fn_req = f; xfer_done = 1'b0;
        predict(h, l, f);
        @(negedge clk);
        if (!h && !l && f == '0) begin
            check(grant == '0, "R9 idle no grant", int'(grant), 0);
            return;
        end
        held = grant;
        for (int c = 0; c < hold; c++) begin
            if (disturb) begin
                host_req = ~host_req; link_req = 1'b1; fn_req = ~fn_req;
            end
            @(negedge clk);
            check(grant == held, "R6 grant held", int'(grant), int'(held));
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(grant == '0 && grant_idx == '0, "R7 release on done", int'(grant), 0);
        host_req = 1'b0; link_req = 1'b0; fn_req = '0;
    endtask

    // Monitor: every new grant is compared with the next expected slot.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (grant != '0 && prev_gnt == '0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected grant", int'(grant_idx), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(grant_idx) == e && grant == (NREQ'(1) << e),
                          tag_of(e), int'(grant_idx), e);
                    if (e >= 2) fn_cnt[e-2]++;
                end
            end
            prev_gnt = grant;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_req = 1'b1; link_req = 1'b1; fn_req = '1; xfer_done = 1'b0;
        repeat (3) @(negedge clk);
        check(grant == '0 && grant_idx == '0, "R1 reset state", int'(grant), 0);
        host_req = 1'b0; link_req = 1'b0; fn_req = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3: host beats everything; R6 disturb during hold
        round(1, 1, 4'b1111, 3, 1);
        // R4: link beats functions
        round(0, 1, 4'b1010, 2, 1);
        // R5: rotation from pointer 0
        round(0, 0, 4'b0110, 1, 0);
        round(0, 0, 4'b0110, 1, 0);
        round(0, 0, 4'b0110, 1, 0);
        // R9: no requests
        round(0, 0, 4'b0000, 0, 0);
        // R8: stray done while idle, then pointer must be unchanged
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        check(grant == '0, "R8 stray done ignored", int'(grant), 0);
        round(0, 0, 4'b1111, 1, 0);
        // R10: host and link grants leave the pointer alone
        round(1, 0, 4'b1111, 1, 0);
        round(0, 1, 4'b1111, 1, 0);
        round(0, 0, 4'b1111, 2, 0);
        // R5: wrap from the last function
        round(0, 0, 4'b1001, 1, 0);
        round(0, 0, 4'b1001, 1, 0);

        // R11: saturated function requests with host rounds between them
        for (int i = 0; i < N; i++) fn_cnt[i] = 0;
        for (int r = 0; r < 2 * N; r++) begin
            round(1, 0, 4'b1111, 1, 0);
            round(0, 0, 4'b1111, 1, 0);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++)
            check(fn_cnt[i] == 2, "R11 equal share", fn_cnt[i], 2);
        check(exp_q.size() == 0, "R2 all grants seen", exp_q.size(), 0);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule